// File: doc/BRIEF.md
# Pipelined Condition-Flag and Predication Unit

This block keeps the negative (N) and zero (Z) status flags of a floating-point co-processor pipeline and decides, from a 4-bit condition field, whether a decoded micro-op takes effect. Micro-ops enter one per cycle into a D2 stage. They pass through a parameterised number of intermediate stages (two by default) and reach an EXE stage. Four kinds are handled: a direct flag set, a predicated move, a predicated negate (a sign-bit flip) and a conditional branch. Each op carries its source value and a destination index into a small register file.

Predicated data ops and flag writes act in EXE, so a data op issued right behind a flag write already sees the new flags. Branches resolve while they sit in D2. They read the flag register as it stands then, and writes still travelling ahead of them are not yet visible. The flags change only through a flag-set op, or through a move or negate whose condition field holds the unconditional-with-flag-update code (0).

Top module: `flag_pred_unit`

## Requirements
- R1: While reset (active-low `rstN`) is applied and in the first cycle after it is released, both flags read 0, `wbEn` and `brTaken` are 0, and every register file entry reads 0.
- R2: A flag-set op (kind 0) loads N from `inFlagVal[1]` when `inFlagMask[1]` is 1, and loads Z from `inFlagVal[0]` when `inFlagMask[0]` is 1. A flag whose mask bit is 0 is kept. The new values are visible from the cycle after the op leaves EXE, and not while the op is in EXE.
- R3: Move and negate ops test the flags while in EXE. An op issued in the slot right after a flag-set op is therefore decided by the flag values that op wrote.
- R4: Condition codes: 0 always passes (with flag update), 1 EQ (Z=1), 2 NEQ (Z=0), 3 LT (N=1), 4 GEQ (N=0), 5 GT (N=0 and Z=0), 6 LEQ (N=1 or Z=1). Codes 7 to 15 never pass.
- R5: A move (kind 1) whose condition passes asserts `wbEn` in EXE with `wbData` equal to the source and `wbIdx` equal to the destination, and the register file holds that value afterwards. A move whose condition fails does not write, and the destination keeps its contents.
- R6: A negate (kind 2) always writes in EXE. When its condition passes it writes the source with bit 31 inverted. When the condition fails it writes the source unchanged.
- R7: A move or negate with condition 0 sets N to bit 31 of the written value and Z to 1 exactly when bits 30..0 of that value are all 0. Any other condition leaves both flags unchanged, whether it passes or fails.
- R8: A branch (kind 3) drives `brTaken` high, combinationally, during the cycle it sits in D2 when its condition passes against the current flag register. A branch never writes a register or a flag.
- R9: A branch issued 4 or more slots after a flag-set op is decided by that op's flags. A branch issued 3 slots after it is decided by the flags as they were before that op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A micro-op is issued this cycle |
| inKind | input | 2 | 0 flag set, 1 move, 2 negate, 3 branch |
| inCond | input | 4 | Condition code |
| inFlagMask | input | 2 | Flag-set enables, bit 1 N, bit 0 Z |
| inFlagVal | input | 2 | Flag-set values, bit 1 N, bit 0 Z |
| inSrc | input | 32 | Source value |
| inDst | input | 3 | Destination register index |
| rdIdx | input | 3 | Register file read index |
| rdData | output | 32 | Register file read data |
| brTaken | output | 1 | Branch in D2 is taken |
| wbEn | output | 1 | Write-back enable from EXE |
| wbIdx | output | 3 | Write-back register index |
| wbData | output | 32 | Write-back value |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |

## Verification
Every condition code is run against flag states where it should pass and where it should fail, for moves, negates and branches. This separates a wrong code decode from a wrong action taken on the decoded result. Flag-set ops are followed in the very next slot by a move whose outcome differs between old and new flags, which shows whether the EXE-stage test works. A branch at slot distance 3 and another at distance 4 pin down the sampling stage of branches. Condition-0 ops with values 0x80000000, a negated zero and plain positives separate the sign test from the magnitude test. True non-zero conditions applied to a zero value show that flags are updated only under code 0.

// File: rtl/flag_pred_pkg.sv
package flag_pred_pkg;

  typedef enum logic [1:0] {
    OP_FSET = 2'd0,
    OP_MOV  = 2'd1,
    OP_NEG  = 2'd2,
    OP_BR   = 2'd3
  } opKind_e;

  localparam logic [3:0] CC_UNCF = 4'd0;
  localparam logic [3:0] CC_EQ   = 4'd1;
  localparam logic [3:0] CC_NEQ  = 4'd2;
  localparam logic [3:0] CC_LT   = 4'd3;
  localparam logic [3:0] CC_GEQ  = 4'd4;
  localparam logic [3:0] CC_GT   = 4'd5;
  localparam logic [3:0] CC_LEQ  = 4'd6;

  // Strobes from control to datapath for the op in EXE
  typedef struct packed {
    logic wrEn;
    logic doNeg;
  } dpStrobe_t;

  typedef struct packed {
    logic       valid;
    opKind_e    kind;
    logic [3:0] cond;
    logic [1:0] mask;
    logic [1:0] val;
  } ctlStage_t;

  function automatic logic condPass(logic [3:0] cc, logic n, logic z);
    case (cc)
      CC_UNCF: condPass = 1'b1;
      CC_EQ:   condPass = z;
      CC_NEQ:  condPass = !z;
      CC_LT:   condPass = n;
      CC_GEQ:  condPass = !n;
      CC_GT:   condPass = !n && !z;
      CC_LEQ:  condPass = n || z;
      default: condPass = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/flag_pred_ctrl.sv
module flag_pred_ctrl
  import flag_pred_pkg::*;
#(
  parameter int GAP = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inKind,
  input  logic [3:0] inCond,
  input  logic [1:0] inFlagMask,
  input  logic [1:0] inFlagVal,
  input  logic       resN,
  input  logic       resZ,
  output dpStrobe_t  strobe,
  output logic       brTaken,
  output logic       flagN,
  output logic       flagZ
);

  localparam int DEPTH = GAP + 2;
  localparam int EXE   = DEPTH - 1;

  ctlStage_t stg [DEPTH];
  ctlStage_t exe;
  ctlStage_t d2;
  logic      exePass;
  logic      isData;
  logic      fset;
  logic      flagFromRes;
  logic      nextN;
  logic      nextZ;

  assign exe = stg[EXE];
  assign d2  = stg[0];

  always_comb begin
    exePass     = condPass(exe.cond, flagN, flagZ);
    isData      = exe.valid && (exe.kind == OP_MOV || exe.kind == OP_NEG);
    fset        = exe.valid && (exe.kind == OP_FSET);
    flagFromRes = isData && (exe.cond == CC_UNCF);
    strobe.wrEn  = isData && (exePass || exe.kind == OP_NEG);
    strobe.doNeg = (exe.kind == OP_NEG) && exePass;
    nextN = flagN;
    nextZ = flagZ;
    if (fset) begin
      if (exe.mask[1]) nextN = exe.val[1];
      if (exe.mask[0]) nextZ = exe.val[0];
    end else if (flagFromRes) begin
      nextN = resN;
      nextZ = resZ;
    end
  end

  // Branches resolve in D2 against the architectural flag register
  assign brTaken = d2.valid && (d2.kind == OP_BR) && condPass(d2.cond, flagN, flagZ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
      flagN <= 1'b0;
      flagZ <= 1'b0;
    end else begin
      stg[0] <= '{valid: inValid, kind: opKind_e'(inKind), cond: inCond,
                  mask: inFlagMask, val: inFlagVal};
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
      flagN <= nextN;
      flagZ <= nextZ;
    end
  end

  // R7: without a flag-set or condition-0 data op in EXE the flags hold
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(fset || flagFromRes) |=> $stable({flagN, flagZ}));

  // R2: a masked flag-set lands on N one edge after EXE
  a_r2_fset_n: assert property (@(posedge clk) disable iff (!rstN)
    (fset && exe.mask[1]) |=> flagN == $past(exe.val[1]));

  // R7: condition-0 data ops copy the datapath result status into the flags
  a_r7_uncf_flags: assert property (@(posedge clk) disable iff (!rstN)
    (flagFromRes && !fset) |=> (flagN == $past(resN) && flagZ == $past(resZ)));

  // R8: a taken branch never comes with a register write in the same slot
  a_r8_branch_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (exe.valid && exe.kind == OP_BR) |-> !strobe.wrEn);

endmodule

// File: rtl/flag_pred_dp.sv
module flag_pred_dp
  import flag_pred_pkg::*;
#(
  parameter int W    = 32,
  parameter int NREG = 8,
  parameter int GAP  = 2,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [W-1:0]  inSrc,
  input  logic [IW-1:0] inDst,
  input  logic [IW-1:0] rdIdx,
  input  dpStrobe_t     strobe,
  output logic [W-1:0]  rdData,
  output logic [IW-1:0] wbIdx,
  output logic [W-1:0]  wbData,
  output logic          resN,
  output logic          resZ
);

  localparam int DEPTH = GAP + 2;
  localparam int EXE   = DEPTH - 1;

  logic [W-1:0]             srcPipe [DEPTH];
  logic [IW-1:0]            dstPipe [DEPTH];
  logic [NREG-1:0][W-1:0]   regs;
  logic [W-1:0]             exeSrc;

  assign exeSrc = srcPipe[EXE];
  assign wbIdx  = dstPipe[EXE];
  assign wbData = strobe.doNeg ? {~exeSrc[W-1], exeSrc[W-2:0]} : exeSrc;
  assign resN   = wbData[W-1];
  assign resZ   = ~|wbData[W-2:0];
  assign rdData = regs[rdIdx];

  always_ff @(posedge clk) begin
    srcPipe[0] <= inSrc;
    dstPipe[0] <= inDst;
    for (int i = 1; i < DEPTH; i++) begin
      srcPipe[i] <= srcPipe[i-1];
      dstPipe[i] <= dstPipe[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) regs <= '0;
    else if (strobe.wrEn) regs[wbIdx] <= wbData;
  end

  // R5: a failed move (no write strobe) leaves the whole file untouched
  a_r5_no_write_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(regs));

  // R5: a strobed write lands at the EXE destination
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> regs[$past(wbIdx)] == $past(wbData));

endmodule

// File: rtl/flag_pred_unit.sv
module flag_pred_unit
  import flag_pred_pkg::*;
#(
  parameter int W    = 32,
  parameter int NREG = 8,
  parameter int GAP  = 2,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [1:0]    inKind,
  input  logic [3:0]    inCond,
  input  logic [1:0]    inFlagMask,
  input  logic [1:0]    inFlagVal,
  input  logic [W-1:0]  inSrc,
  input  logic [IW-1:0] inDst,
  input  logic [IW-1:0] rdIdx,
  output logic [W-1:0]  rdData,
  output logic          brTaken,
  output logic          wbEn,
  output logic [IW-1:0] wbIdx,
  output logic [W-1:0]  wbData,
  output logic          flagN,
  output logic          flagZ
);

  dpStrobe_t strobe;
  logic      resN;
  logic      resZ;

  flag_pred_ctrl #(.GAP(GAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inKind(inKind),
    .inCond(inCond), .inFlagMask(inFlagMask), .inFlagVal(inFlagVal),
    .resN(resN), .resZ(resZ), .strobe(strobe), .brTaken(brTaken),
    .flagN(flagN), .flagZ(flagZ)
  );

  flag_pred_dp #(.W(W), .NREG(NREG), .GAP(GAP)) u_dp (
    .clk(clk), .rstN(rstN), .inSrc(inSrc), .inDst(inDst), .rdIdx(rdIdx),
    .strobe(strobe), .rdData(rdData), .wbIdx(wbIdx), .wbData(wbData),
    .resN(resN), .resZ(resZ)
  );

  assign wbEn = strobe.wrEn;

endmodule

// File: tb/flag_pred_unit_bench.sv
module flag_pred_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  inKind = '0;
  logic [3:0]  inCond = '0;
  logic [1:0]  inFlagMask = '0;
  logic [1:0]  inFlagVal = '0;
  logic [31:0] inSrc = '0;
  logic [2:0]  inDst = '0;
  logic [2:0]  rdIdx = '0;
  logic [31:0] rdData;
  logic        brTaken;
  logic        wbEn;
  logic [2:0]  wbIdx;
  logic [31:0] wbData;
  logic        flagN;
  logic        flagZ;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flag_pred_unit u_flag_pred_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inKind(inKind),
    .inCond(inCond), .inFlagMask(inFlagMask), .inFlagVal(inFlagVal),
    .inSrc(inSrc), .inDst(inDst), .rdIdx(rdIdx), .rdData(rdData),
    .brTaken(brTaken), .wbEn(wbEn), .wbIdx(wbIdx), .wbData(wbData),
    .flagN(flagN), .flagZ(flagZ)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Issue one op; returns at the negedge where it sits in D2
  task automatic put(logic [1:0] k, logic [3:0] c, logic [1:0] m, logic [1:0] v,
                     logic [31:0] s, logic [2:0] d);
    inValid = 1'b1; inKind = k; inCond = c; inFlagMask = m; inFlagVal = v;
    inSrc = s; inDst = d;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic idle(int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic readReg(logic [2:0] idx, logic [31:0] exp, string tag);
    rdIdx = idx;
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic tReset();
    chk("R1 flagN", {31'd0, flagN}, 32'd0);
    chk("R1 flagZ", {31'd0, flagZ}, 32'd0);
    chk("R1 wbEn", {31'd0, wbEn}, 32'd0);
    chk("R1 brTaken", {31'd0, brTaken}, 32'd0);
    readReg(3'd3, 32'd0, "R1 reg3");
  endtask

  task automatic tFlagSet();
    put(2'd0, 4'd0, 2'b11, 2'b10, 32'd0, 3'd0);
    idle(3);
    chk("R2 flagN not yet in EXE", {31'd0, flagN}, 32'd0);
    idle(1);
    chk("R2 flagN set", {31'd0, flagN}, 32'd1);
    chk("R2 flagZ set", {31'd0, flagZ}, 32'd0);
    put(2'd0, 4'd0, 2'b01, 2'b01, 32'd0, 3'd0);
    idle(4);
    chk("R2 flagN kept by mask", {31'd0, flagN}, 32'd1);
    chk("R2 flagZ masked load", {31'd0, flagZ}, 32'd1);
  endtask

  // flags N=1 Z=1 on entry
  task automatic tMove();
    put(2'd1, 4'd3, 2'b00, 2'b00, 32'h1234_5678, 3'd2);
    idle(3);
    chk("R5 LT pass wbEn", {31'd0, wbEn}, 32'd1);
    chk("R5 LT pass wbIdx", {29'd0, wbIdx}, 32'd2);
    chk("R5 LT pass wbData", wbData, 32'h1234_5678);
    idle(1);
    readReg(3'd2, 32'h1234_5678, "R5 reg2 written");
    put(2'd1, 4'd4, 2'b00, 2'b00, 32'h0000_AAAA, 3'd2);
    idle(3);
    chk("R4 GEQ fail wbEn", {31'd0, wbEn}, 32'd0);
    idle(1);
    readReg(3'd2, 32'h1234_5678, "R5 reg2 kept on fail");
    put(2'd1, 4'd5, 2'b00, 2'b00, 32'h0000_0011, 3'd3);
    idle(3);
    chk("R4 GT fail wbEn", {31'd0, wbEn}, 32'd0);
    idle(1);
    put(2'd1, 4'd6, 2'b00, 2'b00, 32'h0000_0022, 3'd3);
    idle(3);
    chk("R4 LEQ pass wbEn", {31'd0, wbEn}, 32'd1);
    idle(1);
    put(2'd1, 4'd9, 2'b00, 2'b00, 32'h0000_0033, 3'd3);
    idle(3);
    chk("R4 code 9 never wbEn", {31'd0, wbEn}, 32'd0);
    idle(1);
    readReg(3'd3, 32'h0000_0022, "R4 reg3 after never");
    chk("R7 N kept after true non-0 cond", {31'd0, flagN}, 32'd1);
    chk("R7 Z kept after true non-0 cond", {31'd0, flagZ}, 32'd1);
  endtask

  // flags N=1 Z=1 on entry
  task automatic tNeg();
    put(2'd2, 4'd2, 2'b00, 2'b00, 32'h4000_0001, 3'd4);
    idle(3);
    chk("R6 NEQ fail still writes", {31'd0, wbEn}, 32'd1);
    chk("R6 NEQ fail data unchanged", wbData, 32'h4000_0001);
    idle(1);
    put(2'd2, 4'd1, 2'b00, 2'b00, 32'h4000_0001, 3'd4);
    idle(3);
    chk("R6 EQ pass data negated", wbData, 32'hC000_0001);
    idle(1);
    readReg(3'd4, 32'hC000_0001, "R6 reg4 negated");
  endtask

  task automatic tBackToBack();
    put(2'd0, 4'd0, 2'b11, 2'b00, 32'd0, 3'd0);
    put(2'd1, 4'd5, 2'b00, 2'b00, 32'h0000_0055, 3'd5);
    idle(3);
    chk("R3 GT right after flag-set wbEn", {31'd0, wbEn}, 32'd1);
    chk("R3 GT right after flag-set data", wbData, 32'h0000_0055);
    idle(1);
  endtask

  // flags N=0 Z=0 on entry
  task automatic tUncf();
    put(2'd1, 4'd0, 2'b00, 2'b00, 32'h8000_0000, 3'd6);
    idle(3);
    chk("R7 UNCF move wbEn", {31'd0, wbEn}, 32'd1);
    idle(1);
    chk("R7 UNCF -0 flagN", {31'd0, flagN}, 32'd1);
    chk("R7 UNCF -0 flagZ", {31'd0, flagZ}, 32'd1);
    put(2'd2, 4'd0, 2'b00, 2'b00, 32'h8000_0000, 3'd6);
    idle(4);
    chk("R7 UNCF neg flagN", {31'd0, flagN}, 32'd0);
    chk("R7 UNCF neg flagZ", {31'd0, flagZ}, 32'd1);
    put(2'd1, 4'd0, 2'b00, 2'b00, 32'h0000_0100, 3'd6);
    idle(4);
    chk("R7 UNCF positive flagN", {31'd0, flagN}, 32'd0);
    chk("R7 UNCF positive flagZ", {31'd0, flagZ}, 32'd0);
    put(2'd1, 4'd4, 2'b00, 2'b00, 32'h0000_0000, 3'd7);
    idle(3);
    chk("R7 GEQ pass writes zero", {31'd0, wbEn}, 32'd1);
    idle(1);
    chk("R7 GEQ zero leaves flagZ", {31'd0, flagZ}, 32'd0);
  endtask

  // flags N=0 Z=0 on entry
  task automatic tBranch();
    put(2'd3, 4'd2, 2'b00, 2'b00, 32'd0, 3'd1);
    chk("R8 NEQ taken", {31'd0, brTaken}, 32'd1);
    put(2'd3, 4'd1, 2'b00, 2'b00, 32'd0, 3'd1);
    chk("R8 EQ not taken", {31'd0, brTaken}, 32'd0);
    put(2'd3, 4'd5, 2'b00, 2'b00, 32'd0, 3'd1);
    chk("R8 GT taken", {31'd0, brTaken}, 32'd1);
    put(2'd3, 4'd6, 2'b00, 2'b00, 32'd0, 3'd1);
    chk("R8 LEQ not taken", {31'd0, brTaken}, 32'd0);
    put(2'd3, 4'd12, 2'b00, 2'b00, 32'd0, 3'd1);
    chk("R8 code 12 not taken", {31'd0, brTaken}, 32'd0);
    put(2'd3, 4'd0, 2'b00, 2'b00, 32'h8000_0000, 3'd1);
    chk("R8 code 0 taken", {31'd0, brTaken}, 32'd1);
    idle(3);
    chk("R8 branch no write", {31'd0, wbEn}, 32'd0);
    idle(1);
    chk("R8 branch leaves flagN", {31'd0, flagN}, 32'd0);
    chk("R8 branch leaves flagZ", {31'd0, flagZ}, 32'd0);
    readReg(3'd1, 32'd0, "R8 reg1 untouched");
  endtask

  // flags N=0 Z=0 on entry
  task automatic tHazard();
    put(2'd0, 4'd0, 2'b01, 2'b01, 32'd0, 3'd0);
    idle(2);
    put(2'd3, 4'd1, 2'b00, 2'b00, 32'd0, 3'd0);
    chk("R9 EQ at 3 slots sees old Z", {31'd0, brTaken}, 32'd0);
    idle(4);
    put(2'd0, 4'd0, 2'b01, 2'b00, 32'd0, 3'd0);
    idle(3);
    put(2'd3, 4'd2, 2'b00, 2'b00, 32'd0, 3'd0);
    chk("R9 NEQ at 4 slots sees new Z", {31'd0, brTaken}, 32'd1);
    idle(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFlagSet();
    tMove();
    tNeg();
    tBackToBack();
    tUncf();
    tBranch();
    tHazard();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule